// File: doc/BRIEF.md
# Two-Wire Output-Enable Configuration Slave

This block is a write-only target on a two-wire serial bus. It runs on a fast system clock, brings the serial clock line and the serial data line into its own domain, and detects bus START and STOP conditions from their edges. It answers one fixed 7-bit address. It acknowledges every byte it takes by pulling the data line low. It holds two 8-bit output-enable registers, which downstream clock-gating logic reads.

A transfer opens with a START and the address byte with the write direction bit. A command byte and a byte-count byte follow. Both are acknowledged, and their values have no effect. The data bytes then map by position: the first goes to enable bank 0 and the second to enable bank 1. Any later data bytes are acknowledged and dropped. The data line is open-drain: the block reads the resolved line on one input and drives a pull-low enable on one output. The system clock must run at least ten times faster than the serial clock, which runs at up to 100 kHz.

Top module: `twl_cfg_slave`

## Requirements
- R1: After reset, bank 0 reads FFh, bank 1 reads C0h, and the pull-low output is released.
- R2: An address byte of D2h is acknowledged by pulling the data line low through the ninth clock of that byte. D2h is the address 1101001 followed by a direction bit of 0, sent MSB first.
- R3: An address byte other than D2h, including D3h (direction bit 1), gets no acknowledge. The block then acknowledges nothing and changes no register until the next START.
- R4: The command byte and the byte-count byte are acknowledged whatever their values. The count does not limit how many data bytes are accepted.
- R5: The first data byte, MSB first on the wire, is written to bank 0.
- R6: The second data byte is written to bank 1. Bits 5..0 of bank 1 always read 0, whatever value is written to them.
- R7: Data bytes after the second are acknowledged and leave both banks unchanged.
- R8: A STOP or a repeated START before a byte is complete aborts the transfer. Bytes acknowledged before the abort keep their values, and the partial byte is never written. After a repeated START, a new transfer is accepted at once.
- R9: A transfer that ends after one data byte changes bank 0 only, and bank 1 keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Resolved serial data line |
| sda_pull_o | output | 1 | Pull-low enable for the data line (1 = drive low) |
| en_bank0_o | output | 8 | Enable register bank 0 |
| en_bank1_o | output | 8 | Enable register bank 1 (bits 5..0 read 0) |

## Verification
The bench targets three cases.

- **Wrong address and read direction.** A read-direction address and a foreign address must each be followed by D2h-shaped bytes with no START between them. A design that re-arms its address matcher after a mismatch would then acknowledge and write.
- **Mid-byte abort.** A STOP and a repeated START are each placed a few bits into a data byte. A design that commits the shift register on abort, or that needs a STOP before it accepts a new address, shows a corrupted bank or a missing acknowledge.
- **Register edge cases.** Writes of all-ones and of 7Fh to bank 1 check that the reserved bits stay zero. A fourth data byte must not alias onto either bank. A single-data-byte transfer must leave bank 1 untouched.

// File: rtl/twl_pkg.sv
package twl_pkg;
  localparam int BYTE_W         = 8;
  localparam int FIRST_DATA_IDX = 3;  // 0: address, 1: command, 2: count
  localparam int NUM_BANKS      = 2;

  typedef enum logic [1:0] {
    LNK_IDLE = 2'd0,
    LNK_RX   = 2'd1,
    LNK_ACK  = 2'd2
  } link_state_e;
endpackage

// File: rtl/twl_line_sync.sv
module twl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= 1'b1;
        else     chain_q <= line_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~last_q;
  assign fall_o  = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/twl_link_fsm.sv
module twl_link_fsm
  import twl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1101001,
  parameter int         IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              sda_pull_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_sel_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [BYTE_W-1:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam int                BCNT_W    = $clog2(BYTE_W + 1);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(FIRST_DATA_IDX + NUM_BANKS);
  localparam logic [IDX_W-1:0]  IDX_DATA0 = IDX_W'(FIRST_DATA_IDX);
  localparam logic [BCNT_W-1:0] BCNT_FULL = BCNT_W'(BYTE_W);

  link_state_e        state_q;
  logic [BCNT_W-1:0]  bitcnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [BYTE_W-1:0]  shift_q;
  logic               ack_hi_q;
  logic               start_det;
  logic               stop_det;

  assign start_det = scl_lvl & sda_fall;
  assign stop_det  = scl_lvl & sda_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= LNK_IDLE;
      bitcnt_q   <= '0;
      idx_q      <= '0;
      shift_q    <= '0;
      ack_hi_q   <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_sel_o   <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        state_q    <= LNK_RX;
        bitcnt_q   <= '0;
        idx_q      <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state_q    <= LNK_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state_q)
          LNK_RX: begin
            if (scl_rise && bitcnt_q < BCNT_FULL) begin
              shift_q  <= {shift_q[BYTE_W-2:0], sda_lvl};
              bitcnt_q <= bitcnt_q + 1'b1;
            end else if (scl_fall && bitcnt_q == BCNT_FULL) begin
              if (idx_q == '0 && shift_q != ADDR_BYTE) begin
                state_q <= LNK_IDLE;
              end else begin
                state_q    <= LNK_ACK;
                sda_pull_o <= 1'b1;
                ack_hi_q   <= 1'b0;
                if (idx_q >= IDX_DATA0) begin
                  wr_en_o   <= 1'b1;
                  wr_sel_o  <= idx_q - IDX_DATA0;
                  wr_data_o <= shift_q;
                end
              end
            end
          end
          LNK_ACK: begin
            if (scl_rise) begin
              ack_hi_q <= 1'b1;
            end else if (scl_fall && ack_hi_q) begin
              sda_pull_o <= 1'b0;
              state_q    <= LNK_RX;
              bitcnt_q   <= '0;
              if (idx_q != IDX_LAST) idx_q <= idx_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the pull may only move while the serial clock is low
  assert_pull_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (scl_lvl && $past(scl_lvl) && !$past(start_det || stop_det)) |-> $stable(sda_pull_o));

  // R3: an idle (ignoring) link never pulls the line
  assert_idle_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == LNK_IDLE && !start_det) |=> !sda_pull_o);

  // R8: a STOP always releases the line and parks the link
  assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!sda_pull_o && state_q == LNK_IDLE));

  // R8: a write is only issued for a completely shifted byte
  assert_full_byte_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (bitcnt_q == BCNT_FULL && state_q == LNK_ACK));
endmodule

// File: rtl/twl_enable_regs.sv
module twl_enable_regs
  import twl_pkg::*;
#(
  parameter int                          NREG     = NUM_BANKS,
  parameter int                          IDX_W    = 3,
  parameter logic [NREG*BYTE_W-1:0]      RST_VALS = {8'hC0, 8'hFF},
  parameter logic [NREG*BYTE_W-1:0]      LIVE_MSK = {8'hC0, 8'hFF}
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en_i,
  input  logic [IDX_W-1:0]              wr_sel_i,
  input  logic [BYTE_W-1:0]             wr_data_i,
  output logic [NREG-1:0][BYTE_W-1:0]   banks_o
);
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_bank
      localparam logic [BYTE_W-1:0] RV = RST_VALS[g*BYTE_W +: BYTE_W];
      localparam logic [BYTE_W-1:0] LM = LIVE_MSK[g*BYTE_W +: BYTE_W];
      always_ff @(posedge clk) begin
        if (rst)
          banks_o[g] <= RV & LM;
        else if (wr_en_i && wr_sel_i == IDX_W'(g))
          banks_o[g] <= wr_data_i & LM;
      end

      // R6: masked (reserved) bits never become set
      assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (banks_o[g] & ~LM) == '0);
    end
  endgenerate

  // R7: without a write strobe no bank moves
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(banks_o));
endmodule

// File: rtl/twl_cfg_slave.sv
module twl_cfg_slave
  import twl_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1101001,
  parameter logic [7:0] BANK0_RST   = 8'hFF,
  parameter logic [7:0] BANK1_RST   = 8'hC0,
  parameter logic [7:0] BANK1_LIVE  = 8'hC0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] en_bank0_o,
  output logic [7:0] en_bank1_o
);
  localparam int IDX_W = $clog2(FIRST_DATA_IDX + NUM_BANKS + 1);

  logic [1:0] raw_lines;
  logic [1:0] lvl, rise, fall;

  assign raw_lines = {sda_i, scl_i};

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_sync
      twl_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (raw_lines[l]),
        .level_o(lvl[l]),
        .rise_o (rise[l]),
        .fall_o (fall[l])
      );
    end
  endgenerate

  logic                          wr_en;
  logic [IDX_W-1:0]              wr_sel;
  logic [BYTE_W-1:0]             wr_data;
  logic [NUM_BANKS-1:0][BYTE_W-1:0] banks;

  twl_link_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) i_link (
    .clk       (clk),
    .rst       (rst),
    .scl_lvl   (lvl[0]),
    .scl_rise  (rise[0]),
    .scl_fall  (fall[0]),
    .sda_lvl   (lvl[1]),
    .sda_rise  (rise[1]),
    .sda_fall  (fall[1]),
    .sda_pull_o(sda_pull_o),
    .wr_en_o   (wr_en),
    .wr_sel_o  (wr_sel),
    .wr_data_o (wr_data)
  );

  twl_enable_regs #(
    .NREG    (NUM_BANKS),
    .IDX_W   (IDX_W),
    .RST_VALS({BANK1_RST, BANK0_RST}),
    .LIVE_MSK({BANK1_LIVE, 8'hFF})
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en),
    .wr_sel_i (wr_sel),
    .wr_data_i(wr_data),
    .banks_o  (banks)
  );

  assign en_bank0_o = banks[0];
  assign en_bank1_o = banks[1];

  // R1: reset leaves the line released
  assert_reset_release_R1: assert property (@(posedge clk)
    $past(rst) |-> !sda_pull_o);
endmodule

// File: tb/test_twl_cfg_slave.sv
module test_twl_cfg_slave;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [7:0] b0, b1;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  twl_cfg_slave i_twl_cfg_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .en_bank0_o(b0), .en_bank1_o(b1)
  );

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req, input logic [7:0] e0, input logic [7:0] e1);
    @(negedge clk);
    chk(b0 == e0, {req, " bank0"}, b0, e0);
    chk(b1 == e1, {req, " bank1"}, b1, e1);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    @(negedge clk);
    acked = !sda_line;
    wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic xfer(input logic [7:0] bytes[$], output int n_ack);
    bit a;
    n_ack = 0;
    bus_start();
    foreach (bytes[k]) begin
      send_byte(bytes[k], a);
      if (a) n_ack++;
    end
    bus_stop();
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(sda_pull == 1'b0, "R1 pull released", sda_pull, 0);
    chk_regs("R1", 8'hFF, 8'hC0);
  endtask

  task automatic t_basic;
    int n;
    xfer('{8'hD2, 8'h00, 8'h00, 8'hA5, 8'h80}, n);
    chk(n == 5, "R2/R4 acks", n, 5);
    chk_regs("R5/R6 basic", 8'hA5, 8'h80);
    xfer('{8'hD2, 8'h7E, 8'h01, 8'h3C, 8'hFF}, n);
    chk(n == 5, "R4 odd cmd/count acked", n, 5);
    chk_regs("R6 reserved masked", 8'h3C, 8'hC0);
    xfer('{8'hD2, 8'hFF, 8'hFF, 8'h01, 8'h7F}, n);
    chk_regs("R6 bit pattern 7F", 8'h01, 8'h40);
  endtask

  task automatic t_bad_addr;
    int n;
    xfer('{8'hD3, 8'hD2, 8'h00, 8'h11, 8'h00}, n);
    chk(n == 0, "R3 read dir no ack", n, 0);
    chk_regs("R3 read dir no write", 8'h01, 8'h40);
    xfer('{8'hA2, 8'hD2, 8'hD2, 8'h22, 8'h00}, n);
    chk(n == 0, "R3 foreign addr no ack", n, 0);
    chk_regs("R3 foreign addr no write", 8'h01, 8'h40);
  endtask

  task automatic t_extra;
    int n;
    xfer('{8'hD2, 8'h00, 8'h02, 8'h5A, 8'hC0, 8'h00, 8'h33}, n);
    chk(n == 7, "R7 extra bytes acked", n, 7);
    chk_regs("R7 extra bytes dropped", 8'h5A, 8'hC0);
  endtask

  task automatic t_short;
    int n;
    xfer('{8'hD2, 8'h00, 8'h01, 8'h96}, n);
    chk(n == 4, "R9 acks", n, 4);
    chk_regs("R9 bank1 kept", 8'h96, 8'hC0);
  endtask

  task automatic t_abort;
    bit a;
    int n;
    // STOP three bits into the second data byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_byte(8'h0F, a);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    bus_stop();
    chk_regs("R8 stop mid byte", 8'h0F, 8'hC0);
    // repeated START two bits into the first data byte, then new transfer
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
    send_bit(1'b0); send_bit(1'b1);
    n = 0;
    bus_start();
    send_byte(8'hD2, a); if (a) n++;
    send_byte(8'h00, a); if (a) n++;
    send_byte(8'h00, a); if (a) n++;
    send_byte(8'hE7, a); if (a) n++;
    send_byte(8'h40, a); if (a) n++;
    bus_stop();
    chk(n == 5, "R8 restart accepted", n, 5);
    chk_regs("R8 restart writes", 8'hE7, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wq(5);
    rst = 1'b0;
    wq(3);
    t_reset();
    t_basic();
    t_bad_addr();
    t_extra();
    t_short();
    t_abort();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule